// File: doc/BRIEF.md
# Ring-Oscillator Tamper Frequency Monitor

This block watches two slow sensor oscillators, each formed by a ring of inverters loaded by a capacitive shield pattern. If the chip is thinned or probed, the shield's capacitance changes, and so does the ring's frequency. The block synchronizes each oscillator into the system clock domain and counts its rising edges over a gate window of programmable length. At the end of each window it captures every count and adds a signed per-channel trim. One shared comparator then checks each trimmed count against a programmed expected value, within a tolerance band.

Any count outside the band sets that channel's fault flag and a sticky alarm for the CPU. The alarm stays set until the CPU clears it. The window length, expected value, tolerance and trim values are set during a manufacturing test phase, so that a healthy sensor lands exactly on the target. Outside test mode these settings are locked.

Top module: `tamper_freq_mon`

## Requirements
- R1: Each oscillator input passes through a two-flop synchronizer and a rising-edge detector. Each rising edge adds exactly one to its channel counter, so an oscillator whose period is P system cycles gives W/P counts in a window of W cycles when P divides W. A stopped oscillator gives 0.
- R2: A window lasts the configured number of system cycles. At its end, every channel's count is placed on capCount (channel c at bits [8c+7:8c]) and the counter restarts from zero.
- R3: The 8-bit counter saturates at 255 and never wraps, so an oscillator that runs far too fast shows a capture of 255.
- R4: The trimmed count is the captured count plus a 4-bit two's-complement trim. Channel c takes its trim from cfgTrim bits [4c+3:4c].
- R5: In the two cycles after each capture, the shared comparator checks channel 0 and then channel 1. faultFlag[c] is set when the absolute difference between the trimmed count and the expected value exceeds the tolerance (a tolerance of 0 demands an exact match). It is cleared when the latest window passes.
- R6: Any failing comparison sets alarm. alarm stays set until alarmClr is high, and a failure in the same cycle as a clear wins.
- R7: The window length, expected value, tolerance and trims load only in a cycle where testMode and cfgWrEn are both high. A write attempt at any other time has no effect.
- R8: After reset, alarm, faultFlag and capCount are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscIn | input | 2 | Asynchronous sensor oscillator inputs, one per channel |
| testMode | input | 1 | Manufacturing test phase; unlocks configuration |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWinLen | input | 16 | Gate window length in system cycles |
| cfgExpect | input | 8 | Expected trimmed count |
| cfgTol | input | 4 | Allowed absolute deviation |
| cfgTrim | input | 8 | Per-channel signed 4-bit trims |
| alarmClr | input | 1 | Clears the sticky alarm |
| alarm | output | 1 | Sticky tamper alarm to the CPU |
| faultFlag | output | 2 | Per-channel result of the latest comparison |
| capCount | output | 16 | Raw counts captured at the end of the latest window |

## Verification
The assertions assume that the window length is longer than the two-cycle comparison sequence. They also assume that the oscillator inputs stay low or high for at least one system clock period, so that the synchronizer cannot drop an edge. The stimulus uses windows of 200 and 2000 cycles. The modeled oscillators have half-periods that are whole multiples of the system clock half-period, and they are offset so that their edges never fall on a system clock edge. Every period used divides the window length, which makes each steady-state count exact.

// File: rtl/tfm_pkg.sv
package tfm_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic       winEnd;   // last cycle of the gate window
    logic       cmpValid; // comparator slot active
    logic [3:0] cmpSel;   // channel under comparison
    logic       cfgLoad;  // configuration write accepted
  } tfm_strobe_t;
endpackage

// File: rtl/tfm_ctrl.sv
module tfm_ctrl
  import tfm_pkg::*;
#(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned WIN_W   = 16,
  parameter int unsigned DEF_WIN = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             testMode,
  input  logic             cfgWrEn,
  input  logic [WIN_W-1:0] cfgWinLen,
  input  logic             alarmClr,
  input  logic             cmpFail,
  output tfm_strobe_t      strobe,
  output logic             alarm
);
  localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [WIN_W-1:0] winLenReg;
  logic [WIN_W-1:0] winCnt;
  logic             winEnd;
  logic             cfgLoad;
  logic             cmpBusy;
  logic [SEL_W-1:0] cmpIdx;

  assign cfgLoad = testMode & cfgWrEn;
  assign winEnd  = ({1'b0, winCnt} + 1'b1) >= {1'b0, winLenReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) winLenReg <= WIN_W'(DEF_WIN);
    else if (cfgLoad) winLenReg <= cfgWinLen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       winCnt <= '0;
    else if (winEnd) winCnt <= '0;
    else             winCnt <= winCnt + 1'b1;
  end

  // Comparison sequence: channel 0 .. NUM_CH-1 on consecutive cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpBusy <= 1'b0;
      cmpIdx  <= '0;
    end else if (winEnd) begin
      cmpBusy <= 1'b1;
      cmpIdx  <= '0;
    end else if (cmpBusy) begin
      if (cmpIdx == SEL_W'(NUM_CH - 1)) cmpBusy <= 1'b0;
      else                              cmpIdx  <= cmpIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   alarm <= 1'b0;
    else if (cmpBusy && cmpFail) alarm <= 1'b1;
    else if (alarmClr)           alarm <= 1'b0;
  end

  always_comb begin
    strobe.winEnd   = winEnd;
    strobe.cmpValid = cmpBusy;
    strobe.cmpSel   = 4'(cmpIdx);
    strobe.cfgLoad  = cfgLoad;
  end

  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    alarm && !alarmClr |=> alarm); // R6
  AST_FAIL_RAISES_ALARM: assert property (@(posedge clk) disable iff (!rstN)
    cmpBusy && cmpFail |=> alarm); // R6
  AST_CMP_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    winEnd |=> strobe.cmpValid && strobe.cmpSel == 4'd0); // R5
  AST_WINLEN_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    !(testMode && cfgWrEn) |=> $stable(winLenReg)); // R7
endmodule

// File: rtl/tfm_datapath.sv
module tfm_datapath
  import tfm_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned TRIM_W = 4,
  parameter int unsigned TOL_W  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        oscIn,
  input  tfm_strobe_t              strobe,
  input  logic [CNT_W-1:0]         cfgExpect,
  input  logic [TOL_W-1:0]         cfgTol,
  input  logic [NUM_CH*TRIM_W-1:0] cfgTrim,
  output logic                     cmpFail,
  output logic [NUM_CH-1:0]        faultFlag,
  output logic [NUM_CH*CNT_W-1:0]  capCount
);
  localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned SUM_W = CNT_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]         expReg;
  logic [TOL_W-1:0]         tolReg;
  logic [NUM_CH*TRIM_W-1:0] trimAll;

  logic [CNT_W-1:0]  capMux  [NUM_CH];
  logic [TRIM_W-1:0] trimMux [NUM_CH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expReg  <= '0;
      tolReg  <= '0;
      trimAll <= '0;
    end else if (strobe.cfgLoad) begin
      expReg  <= cfgExpect;
      tolReg  <= cfgTol;
      trimAll <= cfgTrim;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    logic             sync1, sync2, syncPrev;
    logic             risePulse;
    logic [CNT_W-1:0] cnt, cntNext, capR;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sync1    <= 1'b0;
        sync2    <= 1'b0;
        syncPrev <= 1'b0;
      end else begin
        sync1    <= oscIn[c];
        sync2    <= sync1;
        syncPrev <= sync2;
      end
    end

    assign risePulse = sync2 & ~syncPrev;
    assign cntNext   = (risePulse && cnt != CNT_MAX) ? cnt + 1'b1 : cnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt  <= '0;
        capR <= '0;
      end else if (strobe.winEnd) begin
        capR <= cntNext;
        cnt  <= '0;
      end else begin
        cnt  <= cntNext;
      end
    end

    assign capCount[c*CNT_W +: CNT_W] = capR;
    assign capMux[c]  = capR;
    assign trimMux[c] = trimAll[c*TRIM_W +: TRIM_W];

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
      strobe.winEnd |=> cnt == '0); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      cnt == CNT_MAX && !strobe.winEnd |=> cnt == CNT_MAX); // R3
  end

  // Shared comparator
  logic [SEL_W-1:0]        sel;
  logic [CNT_W-1:0]        selCap;
  logic [TRIM_W-1:0]       selTrim;
  logic signed [SUM_W-1:0] trimmed, diff, absDiff;

  assign sel = strobe.cmpSel[SEL_W-1:0];

  always_comb begin
    selCap  = '0;
    selTrim = '0;
    if (32'(sel) < NUM_CH) begin
      selCap  = capMux[sel];
      selTrim = trimMux[sel];
    end
    trimmed = $signed({2'b00, selCap})
            + $signed({{(SUM_W-TRIM_W){selTrim[TRIM_W-1]}}, selTrim});
    diff    = trimmed - $signed({2'b00, expReg});
    absDiff = diff[SUM_W-1] ? -diff : diff;
    cmpFail = absDiff > $signed({{(SUM_W-TOL_W){1'b0}}, tolReg});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                faultFlag      <= '0;
    else if (strobe.cmpValid) faultFlag[sel] <= cmpFail;
  end

  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cfgLoad |=> $stable(expReg) && $stable(tolReg) && $stable(trimAll)); // R7
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cmpValid |=> $stable(faultFlag)); // R5
endmodule

// File: rtl/tamper_freq_mon.sv
module tamper_freq_mon #(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned TRIM_W  = 4,
  parameter int unsigned TOL_W   = 4,
  parameter int unsigned WIN_W   = 16,
  parameter int unsigned DEF_WIN = 256
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        oscIn,
  input  logic                     testMode,
  input  logic                     cfgWrEn,
  input  logic [WIN_W-1:0]         cfgWinLen,
  input  logic [CNT_W-1:0]         cfgExpect,
  input  logic [TOL_W-1:0]         cfgTol,
  input  logic [NUM_CH*TRIM_W-1:0] cfgTrim,
  input  logic                     alarmClr,
  output logic                     alarm,
  output logic [NUM_CH-1:0]        faultFlag,
  output logic [NUM_CH*CNT_W-1:0]  capCount
);
  tfm_pkg::tfm_strobe_t strobe;
  logic cmpFail;

  tfm_ctrl #(.NUM_CH(NUM_CH), .WIN_W(WIN_W), .DEF_WIN(DEF_WIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .testMode(testMode), .cfgWrEn(cfgWrEn),
    .cfgWinLen(cfgWinLen), .alarmClr(alarmClr), .cmpFail(cmpFail),
    .strobe(strobe), .alarm(alarm)
  );

  tfm_datapath #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .TRIM_W(TRIM_W), .TOL_W(TOL_W)) u_dp (
    .clk(clk), .rstN(rstN), .oscIn(oscIn), .strobe(strobe),
    .cfgExpect(cfgExpect), .cfgTol(cfgTol), .cfgTrim(cfgTrim),
    .cmpFail(cmpFail), .faultFlag(faultFlag), .capCount(capCount)
  );
endmodule

// File: tb/tamper_freq_mon_bench.sv
`timescale 1ns/1ps
module tamper_freq_mon_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  oscIn;
  logic        testMode, cfgWrEn, alarmClr;
  logic [15:0] cfgWinLen;
  logic [7:0]  cfgExpect;
  logic [3:0]  cfgTol;
  logic [7:0]  cfgTrim;
  logic        alarm;
  logic [1:0]  faultFlag;
  logic [15:0] capCount;

  int total = 0;
  int bad = 0;
  int curWin = 256;
  int half0 = 40;
  int half1 = 32;

  tamper_freq_mon u_tamper_freq_mon (
    .clk(clk), .rstN(rstN), .oscIn(oscIn), .testMode(testMode),
    .cfgWrEn(cfgWrEn), .cfgWinLen(cfgWinLen), .cfgExpect(cfgExpect),
    .cfgTol(cfgTol), .cfgTrim(cfgTrim), .alarmClr(alarmClr),
    .alarm(alarm), .faultFlag(faultFlag), .capCount(capCount)
  );

  always #4 clk = ~clk; // 125 MHz

  // Oscillator models: every toggle falls at 1 ns mod 4, never on a clock edge
  initial begin
    oscIn[0] = 1'b0;
    #1;
    forever begin
      if (half0 == 0) #8;
      else begin #(half0); oscIn[0] = ~oscIn[0]; end
    end
  end
  initial begin
    oscIn[1] = 1'b0;
    #1;
    forever begin
      if (half1 == 0) #8;
      else begin #(half1); oscIn[1] = ~oscIn[1]; end
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic configure(int win, int expv, int tol, int trim);
    @(negedge clk);
    cfgWinLen = 16'(win); cfgExpect = 8'(expv); cfgTol = 4'(tol); cfgTrim = 8'(trim);
    testMode = 1'b1; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0; testMode = 1'b0;
    curWin = win;
  endtask

  task automatic waitWin(int n);
    repeat (n * curWin) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearAlarm();
    @(negedge clk); alarmClr = 1'b1;
    @(negedge clk); alarmClr = 1'b0;
  endtask

  task automatic t_reset();
    check("R8 alarm", alarm, 0);
    check("R8 faultFlag", faultFlag, 0);
    check("R8 capCount", capCount, 0);
  endtask

  task automatic t_nominal();
    configure(200, 20, 0, 8'hB0); // ch1 trim -5
    waitWin(3); clearAlarm(); waitWin(3);
    check("R1 R2 ch0 count P10", capCount[7:0], 20);
    check("R1 ch1 count P8", capCount[15:8], 25);
    check("R4 R5 trimmed ch1 passes", faultFlag, 0);
    check("R5 no alarm when nominal", alarm, 0);
  endtask

  task automatic t_lock();
    @(negedge clk);
    testMode = 1'b0; cfgWrEn = 1'b1; cfgExpect = 8'd99; cfgWinLen = 16'd50;
    @(negedge clk); cfgWrEn = 1'b0;
    waitWin(3);
    check("R7 expect locked", faultFlag, 0);
    check("R7 window locked", capCount[7:0], 20);
    check("R7 alarm untouched", alarm, 0);
  endtask

  task automatic t_fault();
    half0 = 32; // ch0 speeds up: 25 counts
    waitWin(3);
    check("R5 ch0 count", capCount[7:0], 25);
    check("R5 ch0 fault", faultFlag[0], 1);
    check("R5 ch1 clean", faultFlag[1], 0);
    check("R6 alarm set", alarm, 1);
  endtask

  task automatic t_sticky();
    half0 = 40;
    waitWin(3);
    check("R5 fault follows latest window", faultFlag[0], 0);
    check("R6 alarm sticky", alarm, 1);
    clearAlarm();
    check("R6 alarm cleared", alarm, 0);
  endtask

  task automatic t_tol();
    configure(200, 20, 5, 8'hB0);
    half0 = 32; // diff 5
    waitWin(3);
    check("R5 inside tolerance", faultFlag[0], 0);
    check("R5 alarm quiet in band", alarm, 0);
    configure(200, 20, 4, 8'hB0);
    waitWin(3);
    check("R5 outside tolerance", faultFlag[0], 1);
    half0 = 40;
    waitWin(3); clearAlarm();
  endtask

  task automatic t_sat();
    configure(2000, 255, 0, 8'h00);
    half1 = 8; // 1000 edges per window
    waitWin(3);
    check("R3 saturated count", capCount[15:8], 255);
    check("R3 saturated matches 255", faultFlag[1], 0);
    check("R1 ch0 long window", capCount[7:0], 200);
    check("R5 ch0 mismatch", faultFlag[0], 1);
  endtask

  task automatic t_stop();
    configure(200, 20, 0, 8'h00);
    half0 = 0; half1 = 40;
    waitWin(3);
    check("R1 stopped oscillator", capCount[7:0], 0);
    check("R5 stopped faults", faultFlag[0], 1);
    check("R1 ch1 P10", capCount[15:8], 20);
    check("R5 ch1 clean", faultFlag[1], 0);
  endtask

  initial begin
    rstN = 1'b0; testMode = 1'b0; cfgWrEn = 1'b0; alarmClr = 1'b0;
    cfgWinLen = '0; cfgExpect = '0; cfgTol = '0; cfgTrim = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_nominal();
    t_lock();
    t_fault();
    t_sticky();
    t_tol();
    t_sat();
    t_stop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule